// File: doc/BRIEF.md
# Windowed Change Decision for Wronskian Detection

This block turns the nine per-pixel terms of a 3x3 region of support into a single change or no-change bit. Two sets of nine 8-bit terms arrive together for each pixel: one built from the direct intensity ratio, which reacts to changes in dark zones, and one from the conjugate (inverse) ratio, which reacts to changes in bright zones. Each set passes through its own adder tree. Taps that lie outside the frame are grounded by per-tap pad flags before the tree sees them. Each window sum is then compared with nine times an 8-bit threshold, which is the same as comparing the window mean with the threshold.

A two-bit mode picks which windows may raise the change bit. Robustness to global illumination changes comes from enabling both. A small frame tracker accepts windows from a start-of-frame marker onward. It counts one result per pixel of a WIDTH x HEIGHT frame, with 640 x 480 as the default. It marks the last pixel and then goes back to waiting. The tracker has two states. ST_IDLE waits for a window flagged as start of frame. ST_SCAN counts accepted windows. The transitions are: ST_IDLE to ST_SCAN on a valid window with start of frame when the frame holds more than one pixel; ST_SCAN to ST_IDLE on the last pixel; ST_IDLE stays put on any window without the start flag; ST_SCAN stays put on all other windows.

Top module: `wcd_window_decide`

## Requirements
- R1: The direct window sum (the sum of the nine unpadded direct terms; term k sits at bits [8k+7:8k], k in 0..8 row-major, k=4 the centre) raises a change when it is strictly greater than 9 times i_thr. A sum equal to 9 times i_thr gives no change.
- R2: The conjugate window sum, formed the same way from i_cnj_terms, raises a change under the same strict rule.
- R3: i_mode bit 0 enables the direct decision and bit 1 enables the conjugate decision. 2'b11 reports the OR of both, and 2'b00 never reports a change.
- R4: i_pad bit k set forces term k of both windows to zero. With all nine bits set the result is no change for any threshold.
- R5: Window sums are 12 bits wide and never wrap. Nine terms of 255 with i_thr = 254 give a change (2295 > 2286).
- R6: An accepted window produces o_valid high, with its o_change, exactly one clock later. o_change is low whenever o_valid is low.
- R7: From reset, and after each completed frame, windows are accepted only from one carrying i_sof onward. Earlier valid windows give no o_valid.
- R8: The WIDTH*HEIGHT-th accepted window of a frame has o_eof high with its result. The tracker then returns to waiting for i_sof.
- R9: During and right after reset, o_valid, o_change and o_eof are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| i_valid | input | 1 | A window is present this cycle |
| i_sof | input | 1 | Window is the first pixel of a frame |
| i_dir_terms | input | 72 | Nine direct-ratio terms, term k at [8k+7:8k] |
| i_cnj_terms | input | 72 | Nine conjugate-ratio terms, same layout |
| i_pad | input | 9 | Per-tap grounding flags, bit k for term k |
| i_mode | input | 2 | Bit 0 direct enable, bit 1 conjugate enable |
| i_thr | input | 8 | Mean threshold |
| o_valid | output | 1 | Result present, one clock after the window |
| o_change | output | 1 | Change detected for that pixel |
| o_eof | output | 1 | Result belongs to the last pixel of the frame |

## Verification
The bench puts a window sum exactly on nine times the threshold and one unit above it. A design that compared with greater-or-equal, or compared the sum with the raw threshold, would then report the wrong bit. An all-255 window with a near-maximal threshold catches a tree that is too narrow, because its wrapped sum falls below the threshold. A fully padded window with large terms, and single grounded taps, expose pad flags that are ignored or applied to only one window. Windows sent before start-of-frame and just after the last pixel expose a tracker that accepts too early or never goes back to waiting, which shows up as a stray o_valid or a misplaced o_eof.

// File: rtl/wcd_pkg.sv
package wcd_pkg;
    localparam int TAPS   = 9;
    localparam int TERM_W = 8;
    localparam int SUM_W  = 12;
    localparam int THR_W  = 8;
    localparam int MODE_DIR = 0;
    localparam int MODE_CNJ = 1;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_SCAN = 1'b1
    } frame_state_t;
endpackage

// File: rtl/wcd_sum_tree.sv
module wcd_sum_tree
    import wcd_pkg::*;
#(
    parameter int N_TAPS  = TAPS,
    parameter int T_W     = TERM_W,
    parameter int S_W     = SUM_W
) (
    input  logic [N_TAPS*T_W-1:0] terms,
    input  logic [N_TAPS-1:0]     pad,
    output logic [S_W-1:0]        sum
);
    localparam int LEVELS = $clog2(N_TAPS);
    localparam int LEAVES = 1 << LEVELS;
    localparam int NODES  = 2 * LEAVES - 1;

    logic [S_W-1:0] node [NODES];

    for (genvar k = 0; k < LEAVES; k++) begin : g_leaf
        if (k < N_TAPS) begin : g_tap
            assign node[LEAVES-1+k] = pad[k] ? '0
                : S_W'(terms[k*T_W +: T_W]);
        end else begin : g_empty
            assign node[LEAVES-1+k] = '0;
        end
    end

    for (genvar n = 0; n < LEAVES - 1; n++) begin : g_node
        assign node[n] = node[2*n+1] + node[2*n+2];
    end

    assign sum = node[0];
endmodule

// File: rtl/wcd_compare.sv
module wcd_compare
    import wcd_pkg::*;
#(
    parameter int S_W = SUM_W,
    parameter int H_W = THR_W,
    parameter int N_TAPS = TAPS
) (
    input  logic [S_W-1:0] sum,
    input  logic [H_W-1:0] thr,
    output logic           exceed
);
    logic [S_W-1:0] scaled;

    always_comb begin
        scaled = S_W'(thr) * S_W'(N_TAPS);
        exceed = sum > scaled;
    end
endmodule

// File: rtl/wcd_frame_ctl.sv
module wcd_frame_ctl
    import wcd_pkg::*;
#(
    parameter int PIXELS = 640 * 480
) (
    input  logic clk,
    input  logic rst_n,
    input  logic valid,
    input  logic sof,
    output logic accept,
    output logic last,
    output logic scanning
);
    localparam int CNT_W = $clog2(PIXELS + 1);
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PIXELS - 1);

    frame_state_t    state_q, state_d;
    logic [CNT_W-1:0] cnt_q, cnt_d, pix_idx;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        accept  = 1'b0;
        pix_idx = '0;
        unique case (state_q)
            ST_IDLE: begin
                accept  = valid && sof;
                pix_idx = '0;
            end
            ST_SCAN: begin
                accept  = valid;
                pix_idx = cnt_q;
            end
            default: ;
        endcase
        last = accept && (pix_idx == LAST_IDX);
        if (accept) begin
            if (last) begin
                state_d = ST_IDLE;
                cnt_d   = '0;
            end else begin
                state_d = ST_SCAN;
                cnt_d   = pix_idx + 1'b1;
            end
        end
        scanning = (state_q == ST_SCAN);
    end
endmodule

// File: rtl/wcd_window_decide.sv
module wcd_window_decide
    import wcd_pkg::*;
#(
    parameter int FRAME_W = 640,
    parameter int FRAME_H = 480
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    i_valid,
    input  logic                    i_sof,
    input  logic [TAPS*TERM_W-1:0]  i_dir_terms,
    input  logic [TAPS*TERM_W-1:0]  i_cnj_terms,
    input  logic [TAPS-1:0]         i_pad,
    input  logic [1:0]              i_mode,
    input  logic [THR_W-1:0]        i_thr,
    output logic                    o_valid,
    output logic                    o_change,
    output logic                    o_eof
);
    localparam int PIXELS = FRAME_W * FRAME_H;

    logic [SUM_W-1:0] dir_sum, cnj_sum;
    logic             dir_hit, cnj_hit, decide;
    logic             accept, last, scanning;

    wcd_sum_tree u_dir_tree (
        .terms (i_dir_terms),
        .pad   (i_pad),
        .sum   (dir_sum)
    );

    wcd_sum_tree u_cnj_tree (
        .terms (i_cnj_terms),
        .pad   (i_pad),
        .sum   (cnj_sum)
    );

    wcd_compare u_dir_cmp (
        .sum    (dir_sum),
        .thr    (i_thr),
        .exceed (dir_hit)
    );

    wcd_compare u_cnj_cmp (
        .sum    (cnj_sum),
        .thr    (i_thr),
        .exceed (cnj_hit)
    );

    wcd_frame_ctl #(.PIXELS(PIXELS)) u_ctl (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (i_valid),
        .sof      (i_sof),
        .accept   (accept),
        .last     (last),
        .scanning (scanning)
    );

    always_comb begin
        decide = (i_mode[MODE_DIR] && dir_hit) || (i_mode[MODE_CNJ] && cnj_hit);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid  <= 1'b0;
            o_change <= 1'b0;
            o_eof    <= 1'b0;
        end else begin
            o_valid  <= accept;
            o_change <= accept && decide;
            o_eof    <= last;
        end
    end
endmodule

// File: rtl/wcd_window_decide_chk.sv
module wcd_window_decide_chk
    import wcd_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            i_valid,
    input logic            i_sof,
    input logic [TAPS-1:0] i_pad,
    input logic [1:0]      i_mode,
    input logic            scanning,
    input logic            o_valid,
    input logic            o_change,
    input logic            o_eof
);
    AST_RESULT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        o_valid |-> $past(i_valid)); // R6
    AST_CHANGE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> !o_change); // R6
    AST_MODE_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && $past(i_mode) == 2'b00) |-> !o_change); // R3
    AST_FULL_PAD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        (o_valid && $past(i_pad) == {TAPS{1'b1}}) |-> !o_change); // R4
    AST_IDLE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (i_valid && !i_sof && !scanning) |=> !o_valid); // R7
    AST_EOF_HAS_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        o_eof |-> o_valid); // R8
    AST_EOF_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        o_eof |-> !scanning); // R8
endmodule

bind wcd_window_decide wcd_window_decide_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .i_valid  (i_valid),
    .i_sof    (i_sof),
    .i_pad    (i_pad),
    .i_mode   (i_mode),
    .scanning (scanning),
    .o_valid  (o_valid),
    .o_change (o_change),
    .o_eof    (o_eof)
);

// File: tb/test_wcd_window_decide.sv
module test_wcd_window_decide;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int FW = 4;
    localparam int FH = 3;
    localparam int NPIX = FW * FH;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        i_valid = 1'b0, i_sof = 1'b0;
    logic [71:0] i_dir_terms = '0, i_cnj_terms = '0;
    logic [8:0]  i_pad = '0;
    logic [1:0]  i_mode = '0;
    logic [7:0]  i_thr = '0;
    logic        o_valid, o_change, o_eof;

    int checks = 0, errors = 0;
    bit done = 0;
    bit m_scan = 0;
    int m_idx = 0;

    always #2 clk = ~clk;

    wcd_window_decide #(.FRAME_W(FW), .FRAME_H(FH)) i_wcd_window_decide (
        .clk(clk), .rst_n(rst_n), .i_valid(i_valid), .i_sof(i_sof),
        .i_dir_terms(i_dir_terms), .i_cnj_terms(i_cnj_terms), .i_pad(i_pad),
        .i_mode(i_mode), .i_thr(i_thr),
        .o_valid(o_valid), .o_change(o_change), .o_eof(o_eof)
    );

    function automatic int wsum(logic [71:0] t, logic [8:0] p);
        int s = 0;
        for (int k = 0; k < 9; k++)
            if (!p[k]) s += int'(t[k*8 +: 8]);
        return s;
    endfunction

    function automatic bit expect_change(logic [71:0] d, logic [71:0] c,
                                         logic [8:0] p, logic [1:0] m, logic [7:0] th);
        bit dh = wsum(d, p) > 9 * int'(th);
        bit ch = wsum(c, p) > 9 * int'(th);
        return (m[0] && dh) || (m[1] && ch);
    endfunction

    function automatic logic [71:0] fill(logic [7:0] v);
        logic [71:0] r;
        for (int k = 0; k < 9; k++) r[k*8 +: 8] = v;
        return r;
    endfunction

    task automatic check(string tag, logic act, logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic send(string tag, logic [71:0] d, logic [71:0] c, logic [8:0] p,
                        logic [1:0] m, logic [7:0] th, logic sof);
        bit ev, ec, ee;
        @(negedge clk);
        i_valid = 1'b1; i_sof = sof; i_dir_terms = d; i_cnj_terms = c;
        i_pad = p; i_mode = m; i_thr = th;
        ev = m_scan || sof;
        ec = ev && expect_change(d, c, p, m, th);
        ee = 1'b0;
        if (ev) begin
            if (!m_scan) m_idx = 0;
            ee = (m_idx == NPIX - 1);
            if (ee) begin m_scan = 0; m_idx = 0; end
            else begin m_scan = 1; m_idx++; end
        end
        @(negedge clk);
        i_valid = 1'b0; i_sof = 1'b0;
        check(ev ? "R6 valid" : "R7 dropped", o_valid, ev);
        check(tag, o_change, ec);
        check("R8 eof", o_eof, ee);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        check("R9 valid in reset", o_valid, 1'b0);
        check("R9 change in reset", o_change, 1'b0);
        check("R9 eof in reset", o_eof, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", o_valid, 1'b0);

        // R7: windows before start of frame are dropped
        send("R7 pre-sof", fill(8'd200), fill(8'd200), 9'h0, 2'b11, 8'd1, 1'b0);
        // R1 boundary cases inside the frame
        send("R1 zero vs zero", fill(8'd0), fill(8'd0), 9'h0, 2'b01, 8'd0, 1'b1);
        send("R1 equal no change", fill(8'd10), fill(8'd0), 9'h0, 2'b01, 8'd10, 1'b0);
        send("R1 one above", fill(8'd10) + 72'd1, fill(8'd0), 9'h0, 2'b01, 8'd10, 1'b0);
        // R2 conjugate only
        send("R2 conj hit", fill(8'd0), fill(8'd90), 9'h0, 2'b10, 8'd80, 1'b0);
        send("R2 conj ignores direct", fill(8'd90), fill(8'd0), 9'h0, 2'b10, 8'd80, 1'b0);
        // R3 modes
        send("R3 mode off", fill(8'd255), fill(8'd255), 9'h0, 2'b00, 8'd0, 1'b0);
        send("R3 both via direct", fill(8'd90), fill(8'd0), 9'h0, 2'b11, 8'd80, 1'b0);
        send("R3 both via conj", fill(8'd0), fill(8'd90), 9'h0, 2'b11, 8'd80, 1'b0);
        // R4 padding
        send("R4 full pad", fill(8'd255), fill(8'd255), 9'h1FF, 2'b11, 8'd0, 1'b0);
        send("R4 centre pad", fill(8'd10) + (72'd9 << 32), fill(8'd0), 9'h010, 2'b01, 8'd8, 1'b0);
        // R5 no overflow
        send("R5 max sum", fill(8'd255), fill(8'd255), 9'h0, 2'b01, 8'd254, 1'b0);
        // frame of 12 ends on the next window
        send("R8 last pixel", fill(8'd50), fill(8'd40), 9'h0, 2'b11, 8'd45, 1'b0);
        send("R8 after frame", fill(8'd50), fill(8'd40), 9'h0, 2'b11, 8'd45, 1'b0);

        // random frames
        for (int f = 0; f < 25; f++) begin
            for (int n = 0; n < NPIX + 2; n++) begin
                logic [71:0] d, c;
                logic [7:0] th = 8'($urandom_range(40, 200));
                for (int k = 0; k < 9; k++) begin
                    d[k*8 +: 8] = 8'($urandom_range(int'(th) - 40, int'(th) + 40));
                    c[k*8 +: 8] = 8'($urandom_range(int'(th) - 40, int'(th) + 40));
                end
                send("R1 R2 R3 R4 random", d, c, 9'($urandom & $urandom),
                     2'($urandom), th, (n == 0) || ($urandom_range(0, 15) == 0));
                if ($urandom_range(0, 3) == 0) @(negedge clk);
            end
        end

        done = 1;
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule